// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the four active-low control strobes and the multiplexed address bus of an asynchronous DRAM interface. It samples them with a clock much faster than the DRAM cycle and names each memory cycle it sees. A cycle type follows from the order in which the strobe edges arrive, not from the levels at a single instant. Each time a cycle is resolved, the block issues a one-cycle report. The report carries a class code, the row address captured when the row strobe fell, and the column address captured when the column strobe fell.

The block also measures how long the row strobe stays low and how long it stays high, counted in sample clocks. It raises a one-cycle error flag when either interval is shorter than a parameter. It is intended for use as a passive checker in a testbench, or for debugging a memory bus inside a chip. It checks neither data values nor timing finer than one sample period.

Top module: `dram_cycle_classifier`

## Requirements
- R1: After reset, `cls_valid`, `err_ras_short` and `err_pre_short` are low and `cls_code` is 0.
- R2: Row strobe falls, then the column strobe falls with write-enable high, and the write-enable stays high until the column strobe rises. The block reports code 1 (read) with the row and column captured at those two falls.
- R3: Write-enable already low in the sample where the column strobe falls gives code 2 (early write).
- R4: Write-enable falls while the column strobe is low. If output-enable stayed high throughout, the code is 3 (delayed write). If output-enable was sampled low at any point since the column fall, the code is 4 (read-modify-write).
- R5: Only the first column pulse within one row-low period takes codes 1 to 4. Every further column pulse in that period gives code 5 (page continuation), with the same row and the new column. The reported row changes only after a row-strobe fall.
- R6: A row-low period with no column fall gives code 6 (row-only refresh) when the row strobe rises, with the row captured at its fall.
- R7: If the column strobe was already low before the row strobe falls, the block reports at that row fall. The code is 7 (column-before-row refresh) if write-enable is high, and 9 (test-mode entry) if it is low. Neither the row output nor the column output changes.
- R8: A column access whose row strobe rises while the column strobe stays low is reported at that rise. A following row fall with the column strobe still low gives code 8 (hidden refresh). The later rises of both strobes give no report.
- R9: Every report is a single-cycle pulse of `cls_valid`, `SYNC_STAGES`+1 clocks after the deciding input sample. No report appears without a deciding event.
- R10: `err_ras_short` pulses when the row strobe rises after fewer than `MIN_RAS_LOW` low samples.
- R11: `err_pre_short` pulses when the row strobe falls after fewer than `MIN_RAS_HIGH` high samples.
- R12: When the row strobe and the column strobe fall in the same sample, the cycle is an ordinary access, and both row and column are taken from that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed address bus |
| cls_valid | output | 1 | One-cycle report strobe |
| cls_code | output | 4 | Class code of the report |
| row_addr | output | ADDR_W | Captured row address |
| col_addr | output | ADDR_W | Captured column address |
| err_ras_short | output | 1 | Row-low interval too short |
| err_pre_short | output | 1 | Row-high interval too short |

## Verification
Inputs pass through `SYNC_STAGES` synchronising registers. Edge detection then compares adjacent samples, and one more register holds the outputs. Each report and each error pulse is therefore due exactly `SYNC_STAGES`+1 clocks after the input sample that decides it; with the default of 2 stages, that is three clocks. At the deciding drive step, the driver stamps each expected item with the current cycle plus that latency. The monitor compares code, row, column and arrival cycle on every `cls_valid` or error pulse. Any pulse that arrives early, late, unrequested or not at all is reported as a failure.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [3:0] {
        CLS_NONE     = 4'd0,
        CLS_READ     = 4'd1,
        CLS_EARLY_WR = 4'd2,
        CLS_LATE_WR  = 4'd3,
        CLS_RMW      = 4'd4,
        CLS_PAGE     = 4'd5,
        CLS_ROW_ONLY = 4'd6,
        CLS_CBR      = 4'd7,
        CLS_HIDDEN   = 4'd8,
        CLS_TEST     = 4'd9
    } cls_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic oe_n;
    } strb_t;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_rise;
        logic we_fall;
        logic cas_was_low;
    } edge_t;

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
    import dcc_pkg::*;
#(
    parameter int unsigned STAGES = 2,
    parameter int unsigned AW     = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strb_t         raw,
    input  logic [AW-1:0] addr_raw,
    output strb_t         cur,
    output logic [AW-1:0] addr_cur,
    output edge_t         edges
);

    localparam int unsigned DEPTH = STAGES + 1;
    localparam strb_t       IDLE  = strb_t'(4'hF);

    typedef struct packed {
        strb_t [DEPTH-1:0]           ctl;
        logic  [STAGES-1:0][AW-1:0]  adr;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    strb_t prev;

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.ctl[0] = raw;
        pipe_d.adr[0] = addr_raw;
        for (int i = 1; i < int'(DEPTH); i++) begin
            pipe_d.ctl[i] = pipe_q.ctl[i-1];
        end
        for (int i = 1; i < int'(STAGES); i++) begin
            pipe_d.adr[i] = pipe_q.adr[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q.ctl <= {DEPTH{IDLE}};
            pipe_q.adr <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign cur      = pipe_q.ctl[STAGES-1];
    assign prev     = pipe_q.ctl[STAGES];
    assign addr_cur = pipe_q.adr[STAGES-1];

    always_comb begin
        edges.ras_fall    =  prev.ras_n & ~cur.ras_n;
        edges.ras_rise    = ~prev.ras_n &  cur.ras_n;
        edges.cas_fall    =  prev.cas_n & ~cur.cas_n;
        edges.cas_rise    = ~prev.cas_n &  cur.cas_n;
        edges.we_fall     =  prev.we_n  & ~cur.we_n;
        edges.cas_was_low = ~prev.cas_n;
    end

endmodule

// File: rtl/ras_width_check.sv
module ras_width_check #(
    parameter int unsigned MIN_LOW  = 4,
    parameter int unsigned MIN_HIGH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_fall,
    input  logic ras_rise,
    output logic err_low,
    output logic err_pre
);

    localparam int unsigned CMAX = (MIN_LOW > MIN_HIGH) ? MIN_LOW : MIN_HIGH;
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] LIM_LOW  = CW'(MIN_LOW);
    localparam logic [CW-1:0] LIM_HIGH = CW'(MIN_HIGH);
    localparam logic [CW-1:0] SAT      = CW'(CMAX);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          e_low;
        logic          e_pre;
    } wc_t;

    wc_t w_d, w_q;

    always_comb begin
        w_d       = w_q;
        w_d.e_low = ras_rise && (w_q.cnt < LIM_LOW);
        w_d.e_pre = ras_fall && (w_q.cnt < LIM_HIGH);
        if (ras_rise || ras_fall) begin
            w_d.cnt = CW'(1);
        end else if (w_q.cnt != SAT) begin
            w_d.cnt = w_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q.cnt   <= SAT;
            w_q.e_low <= 1'b0;
            w_q.e_pre <= 1'b0;
        end else begin
            w_q <= w_d;
        end
    end

    assign err_low = w_q.e_low;
    assign err_pre = w_q.e_pre;

    p_low_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_low |-> $past(ras_rise));

    p_pre_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_pre |-> $past(ras_fall));

    p_err_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_low && err_pre));

endmodule

// File: rtl/cycle_decoder.sv
module cycle_decoder
    import dcc_pkg::*;
#(
    parameter int unsigned AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strb_t         cur,
    input  logic [AW-1:0] addr_cur,
    input  edge_t         edges,
    output logic          valid,
    output cls_e          code,
    output logic [AW-1:0] row,
    output logic [AW-1:0] col
);

    typedef struct packed {
        logic          valid;
        cls_e          code;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        logic          acc_open;
        logic          first;
        logic          col_seen;
        logic          we_early;
        logic          we_late;
        logic          rmw;
        logic          oe_seen;
        logic          hold;
        logic          refresh;
    } dec_t;

    dec_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.code  = CLS_NONE;

        // track write-enable and output-enable while a column access is open
        if (s_q.acc_open && !cur.cas_n) begin
            if (!cur.oe_n) begin
                s_d.oe_seen = 1'b1;
            end
            if (edges.we_fall && !s_q.we_early && !s_q.we_late) begin
                s_d.we_late = 1'b1;
                s_d.rmw     = s_q.oe_seen;
            end
        end

        // close an open access on either strobe rising
        if (s_q.acc_open && (edges.cas_rise || edges.ras_rise)) begin
            s_d.valid    = 1'b1;
            s_d.acc_open = 1'b0;
            if (!s_q.first)         s_d.code = CLS_PAGE;
            else if (s_q.we_early)  s_d.code = CLS_EARLY_WR;
            else if (s_q.we_late)   s_d.code = s_q.rmw ? CLS_RMW : CLS_LATE_WR;
            else                    s_d.code = CLS_READ;
            if (edges.ras_rise && !cur.cas_n) begin
                s_d.hold = 1'b1;
            end
        end

        if (edges.ras_rise) begin
            if (!s_q.col_seen && !s_q.refresh) begin
                s_d.valid = 1'b1;
                s_d.code  = CLS_ROW_ONLY;
            end
            s_d.refresh = 1'b0;
        end

        if (edges.cas_rise) begin
            s_d.hold = 1'b0;
        end

        if (edges.ras_fall) begin
            if (edges.cas_was_low) begin
                s_d.valid   = 1'b1;
                s_d.refresh = 1'b1;
                if (s_q.hold)        s_d.code = CLS_HIDDEN;
                else if (!cur.we_n)  s_d.code = CLS_TEST;
                else                 s_d.code = CLS_CBR;
                s_d.hold = 1'b0;
            end else begin
                s_d.row      = addr_cur;
                s_d.col_seen = 1'b0;
                s_d.refresh  = 1'b0;
            end
        end

        if (edges.cas_fall && !cur.ras_n && !s_q.refresh) begin
            s_d.col      = addr_cur;
            s_d.acc_open = 1'b1;
            s_d.first    = edges.ras_fall || !s_q.col_seen;
            s_d.col_seen = 1'b1;
            s_d.we_early = !cur.we_n;
            s_d.we_late  = 1'b0;
            s_d.rmw      = 1'b0;
            s_d.oe_seen  = !cur.oe_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{valid: 1'b0, code: CLS_NONE, row: '0, col: '0,
                     acc_open: 1'b0, first: 1'b0, col_seen: 1'b0,
                     we_early: 1'b0, we_late: 1'b0, rmw: 1'b0,
                     oe_seen: 1'b0, hold: 1'b0, refresh: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign valid = s_q.valid;
    assign code  = s_q.code;
    assign row   = s_q.row;
    assign col   = s_q.col;

    p_code_when_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (code != CLS_NONE));

    p_row_only_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !edges.ras_fall |=> $stable(row));

    p_refresh_keeps_col_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (code == CLS_CBR || code == CLS_TEST || code == CLS_HIDDEN))
            |-> $stable(col));

    p_hidden_cas_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && code == CLS_HIDDEN) |-> $past(edges.cas_was_low && edges.ras_fall));

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
    import dcc_pkg::*;
#(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned MIN_RAS_LOW  = 4,
    parameter int unsigned MIN_RAS_HIGH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cls_valid,
    output logic [3:0]        cls_code,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic              err_ras_short,
    output logic              err_pre_short
);

    strb_t             raw_s, cur_s;
    logic [ADDR_W-1:0] addr_s;
    edge_t             edg;
    cls_e              code_e;

    assign raw_s = '{ras_n: ras_n, cas_n: cas_n, we_n: we_n, oe_n: oe_n};

    strobe_sampler #(.STAGES(SYNC_STAGES), .AW(ADDR_W)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (raw_s),
        .addr_raw (addr),
        .cur      (cur_s),
        .addr_cur (addr_s),
        .edges    (edg)
    );

    cycle_decoder #(.AW(ADDR_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (cur_s),
        .addr_cur (addr_s),
        .edges    (edg),
        .valid    (cls_valid),
        .code     (code_e),
        .row      (row_addr),
        .col      (col_addr)
    );

    ras_width_check #(.MIN_LOW(MIN_RAS_LOW), .MIN_HIGH(MIN_RAS_HIGH)) u_wid (
        .clk      (clk),
        .rst_n    (rst_n),
        .ras_fall (edg.ras_fall),
        .ras_rise (edg.ras_rise),
        .err_low  (err_ras_short),
        .err_pre  (err_pre_short)
    );

    assign cls_code = code_e;

endmodule

// File: tb/sim_dram_cycle_classifier.sv
`timescale 1ns/1ps
module sim_dram_cycle_classifier;

    localparam int AW  = 13;
    localparam int LAT = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cls_valid, err_ras_short, err_pre_short;
    logic [3:0]    cls_code;
    logic [AW-1:0] row_addr, col_addr;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 0;

    typedef struct {
        logic [3:0]    code;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        int            due;
        string         tag;
    } item_t;

    item_t cls_q[$];
    int    elow_q[$];
    int    epre_q[$];

    dram_cycle_classifier #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .cls_valid(cls_valid), .cls_code(cls_code),
        .row_addr(row_addr), .col_addr(col_addr),
        .err_ras_short(err_ras_short), .err_pre_short(err_pre_short)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic step(input bit r, input bit c, input bit w, input bit o,
                        input logic [AW-1:0] a);
        @(negedge clk);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
    endtask

    task automatic idle(input int n);
        repeat (n) step(1, 1, 1, 1, '0);
    endtask

    task automatic exp_cls(input logic [3:0] code, input logic [AW-1:0] row,
                           input logic [AW-1:0] col, input string tag);
        item_t it;
        it.code = code; it.row = row; it.col = col; it.due = cyc + LAT; it.tag = tag;
        cls_q.push_back(it);
    endtask

    // monitor: pops expected items when the design reports
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cls_valid) begin
                total++;
                if (cls_q.size() == 0) begin
                    bad++;
                    $display("FAIL R9 unexpected report: actual code=%0d cyc=%0d expected none",
                             cls_code, cyc);
                end else begin
                    item_t e;
                    e = cls_q.pop_front();
                    if (cls_code !== e.code || row_addr !== e.row ||
                        col_addr !== e.col || cyc != e.due) begin
                        bad++;
                        $display("FAIL %s (R9 timing): actual code=%0d row=%h col=%h cyc=%0d expected code=%0d row=%h col=%h cyc=%0d",
                                 e.tag, cls_code, row_addr, col_addr, cyc,
                                 e.code, e.row, e.col, e.due);
                    end
                end
            end
            if (err_ras_short) begin
                total++;
                if (elow_q.size() == 0) begin
                    bad++;
                    $display("FAIL R10 unexpected low-width error: actual cyc=%0d expected none", cyc);
                end else begin
                    int d;
                    d = elow_q.pop_front();
                    if (d != cyc) begin
                        bad++;
                        $display("FAIL R10 low-width error: actual cyc=%0d expected cyc=%0d", cyc, d);
                    end
                end
            end
            if (err_pre_short) begin
                total++;
                if (epre_q.size() == 0) begin
                    bad++;
                    $display("FAIL R11 unexpected precharge error: actual cyc=%0d expected none", cyc);
                end else begin
                    int d;
                    d = epre_q.pop_front();
                    if (d != cyc) begin
                        bad++;
                        $display("FAIL R11 precharge error: actual cyc=%0d expected cyc=%0d", cyc, d);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: reset state
        total++;
        if (cls_valid !== 1'b0 || cls_code !== 4'd0 ||
            err_ras_short !== 1'b0 || err_pre_short !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: actual v=%b c=%0d el=%b ep=%b expected 0 0 0 0",
                     cls_valid, cls_code, err_ras_short, err_pre_short);
        end

        // R2: plain read
        idle(3);
        step(0, 1, 1, 1, 13'h123);
        step(0, 0, 1, 1, 13'h045);
        step(0, 0, 1, 0, '0);
        step(0, 1, 1, 1, '0); exp_cls(4'd1, 13'h123, 13'h045, "R2");
        step(0, 1, 1, 1, '0);
        step(1, 1, 1, 1, '0);
        idle(3);

        // R3: early write
        step(0, 1, 1, 1, 13'h0AA);
        step(0, 0, 0, 1, 13'h1F0);
        step(0, 0, 0, 1, '0);
        step(0, 1, 1, 1, '0); exp_cls(4'd2, 13'h0AA, 13'h1F0, "R3");
        step(0, 1, 1, 1, '0);
        step(1, 1, 1, 1, '0);
        idle(3);

        // R4: delayed write, output enable high throughout
        step(0, 1, 1, 1, 13'h300);
        step(0, 0, 1, 1, 13'h011);
        step(0, 0, 0, 1, '0);
        step(0, 0, 0, 1, '0);
        step(0, 1, 1, 1, '0); exp_cls(4'd3, 13'h300, 13'h011, "R4");
        step(0, 1, 1, 1, '0);
        step(1, 1, 1, 1, '0);
        idle(3);

        // R4: read-modify-write, output enable low before write-enable falls
        step(0, 1, 1, 1, 13'h301);
        step(0, 0, 1, 0, 13'h012);
        step(0, 0, 1, 0, '0);
        step(0, 0, 0, 1, '0);
        step(0, 1, 1, 1, '0); exp_cls(4'd4, 13'h301, 13'h012, "R4");
        step(0, 1, 1, 1, '0);
        step(1, 1, 1, 1, '0);
        idle(3);

        // R5: page continuation
        step(0, 1, 1, 1, 13'h0F0);
        step(0, 0, 1, 1, 13'h101);
        step(0, 1, 1, 1, '0); exp_cls(4'd1, 13'h0F0, 13'h101, "R5");
        step(0, 0, 1, 1, 13'h102);
        step(0, 1, 1, 1, '0); exp_cls(4'd5, 13'h0F0, 13'h102, "R5");
        step(0, 0, 0, 1, 13'h103);
        step(0, 1, 1, 1, '0); exp_cls(4'd5, 13'h0F0, 13'h103, "R5");
        step(0, 1, 1, 1, '0);
        step(1, 1, 1, 1, '0);
        idle(3);

        // R6: row-only refresh
        step(0, 1, 1, 1, 13'h1AB);
        step(0, 1, 1, 1, '0);
        step(0, 1, 1, 1, '0);
        step(0, 1, 1, 1, '0);
        step(1, 1, 1, 1, '0); exp_cls(4'd6, 13'h1AB, 13'h103, "R6");
        idle(3);

        // R7: column-before-row refresh, outputs keep last row/column
        step(1, 0, 1, 1, '0);
        step(1, 0, 1, 1, '0);
        step(0, 0, 1, 1, 13'h055); exp_cls(4'd7, 13'h1AB, 13'h103, "R7");
        repeat (3) step(0, 0, 1, 1, '0);
        step(1, 0, 1, 1, '0);
        step(1, 1, 1, 1, '0);
        idle(3);

        // R7: test-mode entry (write-enable low)
        step(1, 0, 0, 1, '0);
        step(1, 0, 0, 1, '0);
        step(0, 0, 0, 1, 13'h066); exp_cls(4'd9, 13'h1AB, 13'h103, "R7");
        repeat (3) step(0, 0, 1, 1, '0);
        step(1, 0, 1, 1, '0);
        step(1, 1, 1, 1, '0);
        idle(3);

        // R8: read followed by hidden refresh
        step(0, 1, 1, 1, 13'h2C4);
        step(0, 0, 1, 1, 13'h07B);
        step(0, 0, 1, 0, '0);
        step(0, 0, 1, 0, '0);
        step(1, 0, 1, 0, '0); exp_cls(4'd1, 13'h2C4, 13'h07B, "R8");
        step(1, 0, 1, 0, '0);
        step(1, 0, 1, 0, '0);
        step(0, 0, 1, 0, 13'h999); exp_cls(4'd8, 13'h2C4, 13'h07B, "R8");
        repeat (3) step(0, 0, 1, 0, '0);
        step(1, 0, 1, 1, '0);
        step(1, 1, 1, 1, '0);
        idle(3);

        // R10 and R11: short low then short precharge
        step(0, 1, 1, 1, 13'h0CC);
        step(0, 1, 1, 1, '0);
        step(1, 1, 1, 1, '0); exp_cls(4'd6, 13'h0CC, 13'h07B, "R10");
        elow_q.push_back(cyc + LAT);
        step(0, 1, 1, 1, 13'h0DD); epre_q.push_back(cyc + LAT);
        repeat (3) step(0, 1, 1, 1, '0);
        step(1, 1, 1, 1, '0); exp_cls(4'd6, 13'h0DD, 13'h07B, "R11");
        idle(3);

        // R12: both strobes fall in the same sample
        step(0, 0, 1, 1, 13'h155);
        step(0, 0, 1, 0, '0);
        step(0, 1, 1, 1, '0); exp_cls(4'd1, 13'h155, 13'h155, "R12");
        step(0, 1, 1, 1, '0);
        step(0, 1, 1, 1, '0);
        step(1, 1, 1, 1, '0);
        idle(8);

        // R9: every expected item arrived
        total++;
        if (cls_q.size() != 0 || elow_q.size() != 0 || epre_q.size() != 0) begin
            bad++;
            $display("FAIL R9 missing reports: actual pending=%0d expected 0",
                     cls_q.size() + elow_q.size() + epre_q.size());
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule